// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a bank of lock flags shared by two independent agents, called the left and the right port. Each flag guards one shared resource. A port claims a flag by writing a request and then reads the flag back to learn whether the claim succeeded. If the claim failed, the request is queued against the current holder. The flag passes to the waiting port in the same clock edge at which the holder gives it up.

Each port has an active-low select, a write/read strobe, a flag address and a data word. Only the lowest data bit has meaning on a write. Writing 0 asks for the flag. Writing 1 gives it back. A read returns a word that is all zeros when the reading port holds the flag and all ones otherwise. If both ports contend for the same flag on the same edge, the left port always wins. Everything runs on one clock with a synchronous active-low reset.

Top module: `dp_semaphore_unit`

## Requirements
- R1: In the cycle after any clock edge with `rst_n` low, all eight flags are free and no request is queued, so every read returns all ones.
- R2: A port whose select input is high changes no flag state, and its read data is all ones, even for a flag it holds.
- R3: The three address bits of a port pick exactly one of eight flags (0 to 7). An access to one flag leaves the other seven unchanged.
- R4: A write with data bit 0 equal to 0 to a free flag gives that flag to the writing port at that clock edge.
- R5: On a write, only data bit 0 is used. Bits 7 down to 1 have no effect on the outcome.
- R6: A write with data bit 0 equal to 1 frees the flag only if the writing port holds it. The same write from a port that does not hold the flag is ignored.
- R7: A request for a flag held by the other port is queued. At the edge where the holder frees the flag, the flag passes to the queued port.
- R8: If both ports request the same free flag at the same edge, the left port gets the flag and the right port's request is queued.
- R9: The read data is the value 0 on all bits when the port is selected, reading, and holds the addressed flag. In every other case it is the value 1 on all bits. It is valid combinationally in the cycle of the read.
- R10: No flag is ever held by both ports at the same time. A port never has a request queued on a flag it holds.
- R11: If the holder frees a flag at the same edge as the other port requests it, the flag passes straight to the requester.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lft_sel_n | input | 1 | Left port select, active low |
| lft_wr | input | 1 | Left port strobe: 1 writes, 0 reads |
| lft_addr | input | 3 | Left port flag index |
| lft_wdata | input | 8 | Left port write data (bit 0 used) |
| lft_rdata | output | 8 | Left port read data |
| rgt_sel_n | input | 1 | Right port select, active low |
| rgt_wr | input | 1 | Right port strobe: 1 writes, 0 reads |
| rgt_addr | input | 3 | Right port flag index |
| rgt_wdata | input | 8 | Right port write data (bit 0 used) |
| rgt_rdata | output | 8 | Right port read data |

## Verification
The checker tests on every cycle that the two ports never hold the same flag and that a queued request always sits against a flag the other port holds. It also checks that the read data always matches ownership, and that an unselected port reads all ones. On the edge after reset it confirms that all flags are free. It checks hand-over when the holder frees a flag that has a queued request, and the left-wins outcome of a tie.

Only the bench's scenarios can show the following:
- data bits above bit 0 are ignored;
- a release from a port that does not hold the flag is ignored;
- a flag moves from holder to requester when the release and the request land on the same edge;
- an access to one flag leaves the others alone.

For each of these, the bench reads the flags back through the ports and compares them with a reference model.

// File: rtl/sem_pkg.sv
// Package: shared types for the dual-port semaphore unit.
// Assumes: exactly two contending ports, called left and right.
package sem_pkg;

    // Who holds a flag. No encoding is ever shared by both ports.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } sem_owner_e;

endpackage

// File: rtl/sem_port_decode.sv
// Module: sem_port_decode
// Turns one port's select, strobe, address and data bit 0 into a
// one-hot request vector, a one-hot release vector and a read enable.
// Assumes: the caller hands over data bit 0 only; the upper bits play no part.
module sem_port_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                 sel_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wbit,
    output logic [NUM_FLAGS-1:0] req_vec,
    output logic [NUM_FLAGS-1:0] rel_vec,
    output logic                 rd_en
);

    logic wr_en;

    // A write counts only while the port is selected.
    assign wr_en = !sel_n && wr;
    // A read counts only while the port is selected.
    assign rd_en = !sel_n && !wr;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic hit;
        // This flag is addressed by the port.
        assign hit        = (addr == ADDR_W'(g));
        // Data bit 0 low asks for the flag; high gives it back.
        assign req_vec[g] = wr_en && hit && !wbit;
        assign rel_vec[g] = wr_en && hit &&  wbit;
    end

endmodule

// File: rtl/sem_flag_cell.sv
// Module: sem_flag_cell
// Holds one lock flag: its current holder and one queued-request bit per port.
// Assumes: at most one command per port per cycle (the decode guarantees it).
// Rules: a free flag goes to the requester (left wins a tie); a request
// against the other holder is queued; only the holder may free the flag,
// and freeing hands it to a queued or simultaneous requester.
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);

    sem_owner_e own_q, own_d;
    logic       pl_q, pl_d;
    logic       pr_q, pr_d;

    // Next-state rules for holder and queued requests.
    always_comb begin
        own_d = own_q;
        pl_d  = pl_q;
        pr_d  = pr_q;
        case (own_q)
            OWN_NONE: begin
                pl_d = 1'b0;
                pr_d = 1'b0;
                if (l_req) begin
                    own_d = OWN_LEFT;
                    pr_d  = r_req;
                end else if (r_req) begin
                    own_d = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                if (l_rel) begin
                    if (pr_q || r_req) begin
                        own_d = OWN_RIGHT;
                        pr_d  = 1'b0;
                    end else begin
                        own_d = OWN_NONE;
                    end
                end else if (r_req) begin
                    pr_d = 1'b1;
                end
            end
            OWN_RIGHT: begin
                if (r_rel) begin
                    if (pl_q || l_req) begin
                        own_d = OWN_LEFT;
                        pl_d  = 1'b0;
                    end else begin
                        own_d = OWN_NONE;
                    end
                end else if (l_req) begin
                    pl_d = 1'b1;
                end
            end
            default: begin
                own_d = OWN_NONE;
                pl_d  = 1'b0;
                pr_d  = 1'b0;
            end
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= OWN_NONE;
            pl_q  <= 1'b0;
            pr_q  <= 1'b0;
        end else begin
            own_q <= own_d;
            pl_q  <= pl_d;
            pr_q  <= pr_d;
        end
    end

    assign own_l  = (own_q == OWN_LEFT);
    assign own_r  = (own_q == OWN_RIGHT);
    assign pend_l = pl_q;
    assign pend_r = pr_q;

    // Unused release inputs: a release from the non-holder changes nothing,
    // so r_rel is only looked at in the right-holder branch and vice versa.

endmodule

// File: rtl/sem_read_port.sv
// Module: sem_read_port
// Forms one port's read word from the holder bits of all flags.
// Assumes: a combinational read of current state; the result is all
// zeros only for a selected read of a flag that this port holds.
module sem_read_port #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8
) (
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_FLAGS-1:0] own_vec,
    output logic [DATA_W-1:0]    rdata
);

    logic held;

    // Holder bit of the addressed flag.
    assign held  = own_vec[addr];
    // Zeros tell the port it holds the flag; ones mean it does not.
    assign rdata = (rd_en && held) ? '0 : '1;

endmodule

// File: rtl/dp_semaphore_unit.sv
// Module: dp_semaphore_unit (top)
// Eight lock flags shared by a left and a right port, claimed by a
// write-then-read handshake. Each port decodes its access into per-flag
// commands, one cell per flag resolves contention, and a read port per
// side reports ownership.
// Assumes: one clock domain, synchronous active-low reset, DATA_W >= 2.
module dp_semaphore_unit #(
    parameter  int NUM_FLAGS = 8,
    parameter  int DATA_W    = 8,
    localparam int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_sel_n,
    input  logic              lft_wr,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    output logic [DATA_W-1:0] lft_rdata,
    input  logic              rgt_sel_n,
    input  logic              rgt_wr,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic [DATA_W-1:0] rgt_rdata
);

    logic [NUM_FLAGS-1:0] l_req_vec, l_rel_vec;
    logic [NUM_FLAGS-1:0] r_req_vec, r_rel_vec;
    logic [NUM_FLAGS-1:0] own_l_vec, own_r_vec;
    logic [NUM_FLAGS-1:0] pend_l_vec, pend_r_vec;
    logic                 l_rd_en, r_rd_en;
    logic                 unused_wdata_hi;

    // Upper data bits have no meaning for a flag write.
    assign unused_wdata_hi = ^{lft_wdata[DATA_W-1:1], rgt_wdata[DATA_W-1:1]};

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_l (
        .sel_n   (lft_sel_n),
        .wr      (lft_wr),
        .addr    (lft_addr),
        .wbit    (lft_wdata[0]),
        .req_vec (l_req_vec),
        .rel_vec (l_rel_vec),
        .rd_en   (l_rd_en)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_r (
        .sel_n   (rgt_sel_n),
        .wr      (rgt_wr),
        .addr    (rgt_addr),
        .wbit    (rgt_wdata[0]),
        .req_vec (r_req_vec),
        .rel_vec (r_rel_vec),
        .rd_en   (r_rd_en)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
        sem_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_req  (l_req_vec[g]),
            .l_rel  (l_rel_vec[g]),
            .r_req  (r_req_vec[g]),
            .r_rel  (r_rel_vec[g]),
            .own_l  (own_l_vec[g]),
            .own_r  (own_r_vec[g]),
            .pend_l (pend_l_vec[g]),
            .pend_r (pend_r_vec[g])
        );
    end

    sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_l (
        .rd_en   (l_rd_en),
        .addr    (lft_addr),
        .own_vec (own_l_vec),
        .rdata   (lft_rdata)
    );

    sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_r (
        .rd_en   (r_rd_en),
        .addr    (rgt_addr),
        .own_vec (own_r_vec),
        .rdata   (rgt_rdata)
    );

endmodule

// File: rtl/sem_unit_checker.sv
// Module: sem_unit_checker
// Checks the semaphore unit's properties at ports and flag state.
// Assumes: bound into dp_semaphore_unit; state vectors come from its cells.
module sem_unit_checker #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lft_sel_n,
    input logic                 lft_wr,
    input logic [ADDR_W-1:0]    lft_addr,
    input logic                 lft_wd0,
    input logic [DATA_W-1:0]    lft_rdata,
    input logic                 rgt_sel_n,
    input logic                 rgt_wr,
    input logic [ADDR_W-1:0]    rgt_addr,
    input logic                 rgt_wd0,
    input logic [DATA_W-1:0]    rgt_rdata,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r,
    input logic [NUM_FLAGS-1:0] pend_l,
    input logic [NUM_FLAGS-1:0] pend_r
);

    // R1: an edge in reset leaves every flag free with nothing queued.
    p_reset_free_r1: assert property (@(posedge clk)
        !rst_n |=> (own_l == '0 && own_r == '0 && pend_l == '0 && pend_r == '0));

    // R2: an unselected port reads all ones.
    p_idle_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lft_sel_n |-> lft_rdata == '1) and (rgt_sel_n |-> rgt_rdata == '1));

    // R9: a selected read reflects ownership of the addressed flag.
    p_read_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lft_sel_n && !lft_wr) |-> ((lft_rdata == '0) == own_l[lft_addr]));
    p_read_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rgt_sel_n && !rgt_wr) |-> ((rgt_rdata == '0) == own_r[rgt_addr]));

    // R10: never two holders; no port queued on its own flag.
    p_mutex_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);
    p_no_self_queue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_l & own_l) == '0) && ((pend_r & own_r) == '0));

    // R7: a queued request always sits against the other port's hold.
    p_queue_on_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_r & ~own_l) == '0) && ((pend_l & ~own_r) == '0));

    // R7: left frees a flag with right queued -> right holds it next cycle.
    p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lft_sel_n && lft_wr && lft_wd0 && own_l[lft_addr] && pend_r[lft_addr])
        |=> own_r[$past(lft_addr)]);

    // R8: both ports request the same free flag -> left holds, right queued.
    p_tie_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lft_sel_n && lft_wr && !lft_wd0 && !rgt_sel_n && rgt_wr && !rgt_wd0 &&
         lft_addr == rgt_addr && !own_l[lft_addr] && !own_r[lft_addr])
        |=> (own_l[$past(lft_addr)] && pend_r[$past(lft_addr)]));

endmodule

bind dp_semaphore_unit sem_unit_checker #(
    .NUM_FLAGS (NUM_FLAGS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lft_sel_n (lft_sel_n),
    .lft_wr    (lft_wr),
    .lft_addr  (lft_addr),
    .lft_wd0   (lft_wdata[0]),
    .lft_rdata (lft_rdata),
    .rgt_sel_n (rgt_sel_n),
    .rgt_wr    (rgt_wr),
    .rgt_addr  (rgt_addr),
    .rgt_wd0   (rgt_wdata[0]),
    .rgt_rdata (rgt_rdata),
    .own_l     (own_l_vec),
    .own_r     (own_r_vec),
    .pend_l    (pend_l_vec),
    .pend_r    (pend_r_vec)
);

// File: tb/dp_semaphore_unit_tb.sv
`timescale 1ns/1ps
module dp_semaphore_unit_tb;

    localparam int  NF   = 8;
    localparam int  DW   = 8;
    localparam logic [DW-1:0] ONES = '1;
    localparam logic [DW-1:0] ZERO = '0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lft_sel_n, lft_wr, rgt_sel_n, rgt_wr;
    logic [2:0]    lft_addr, rgt_addr;
    logic [DW-1:0] lft_wdata, rgt_wdata, lft_rdata, rgt_rdata;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    // Reference model: 0 free, 1 left holds, 2 right holds.
    int m_own [NF];
    bit m_pl  [NF];
    bit m_pr  [NF];
    logic [DW-1:0] lq, rq;

    always #4 clk = ~clk;

    dp_semaphore_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .lft_sel_n(lft_sel_n), .lft_wr(lft_wr), .lft_addr(lft_addr),
        .lft_wdata(lft_wdata), .lft_rdata(lft_rdata),
        .rgt_sel_n(rgt_sel_n), .rgt_wr(rgt_wr), .rgt_addr(rgt_addr),
        .rgt_wdata(rgt_wdata), .rgt_rdata(rgt_rdata)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd(bit sel_n, bit wr, int a, int me);
        return (!sel_n && !wr && m_own[a] == me) ? ZERO : ONES;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < NF; i++) begin
            m_own[i] = 0; m_pl[i] = 0; m_pr[i] = 0;
        end
    endfunction

    function automatic void model_step(bit ls, bit lw, int la, bit ld,
                                       bit rs, bit rw, int ra, bit rd);
        for (int i = 0; i < NF; i++) begin
            bit rl = !ls && lw && la == i && !ld;
            bit sl = !ls && lw && la == i &&  ld;
            bit rr = !rs && rw && ra == i && !rd;
            bit sr = !rs && rw && ra == i &&  rd;
            case (m_own[i])
                0: if (rl) begin m_own[i] = 1; m_pr[i] = rr; end
                   else if (rr) m_own[i] = 2;
                1: if (sl) begin
                       if (m_pr[i] || rr) begin m_own[i] = 2; m_pr[i] = 0; end
                       else m_own[i] = 0;
                   end else if (rr) m_pr[i] = 1;
                default: if (sr) begin
                       if (m_pl[i] || rl) begin m_own[i] = 1; m_pl[i] = 0; end
                       else m_own[i] = 0;
                   end else if (rl) m_pl[i] = 1;
            endcase
        end
    endfunction

    // One cycle: drive at negedge, check reads (R9) before the edge, step model.
    task automatic cyc(bit ls, bit lw, int la, logic [DW-1:0] ld,
                       bit rs, bit rw, int ra, logic [DW-1:0] rd);
        @(negedge clk);
        lft_sel_n = ls; lft_wr = lw; lft_addr = 3'(la); lft_wdata = ld;
        rgt_sel_n = rs; rgt_wr = rw; rgt_addr = 3'(ra); rgt_wdata = rd;
        #1;
        lq = lft_rdata; rq = rgt_rdata;
        check("R9 left read vs model",  lq, exp_rd(ls, lw, la, 1));
        check("R9 right read vs model", rq, exp_rd(rs, rw, ra, 2));
        @(posedge clk);
        model_step(ls, lw, la, ld[0], rs, rw, ra, rd[0]);
    endtask

    task automatic lwrite(int a, logic [DW-1:0] d);
        cyc(0, 1, a, d, 1, 0, 0, ONES);
    endtask
    task automatic rwrite(int a, logic [DW-1:0] d);
        cyc(1, 0, 0, ONES, 0, 1, a, d);
    endtask
    task automatic both_read(int a);
        cyc(0, 0, a, ONES, 0, 0, a, ONES);
    endtask

    function automatic void summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endfunction

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        lft_sel_n = 1; lft_wr = 0; lft_addr = 0; lft_wdata = ONES;
        rgt_sel_n = 1; rgt_wr = 0; rgt_addr = 0; rgt_wdata = ONES;
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: all flags free after reset.
        for (int a = 0; a < NF; a++) begin
            both_read(a);
            check("R1 left reads free", lq, ONES);
            check("R1 right reads free", rq, ONES);
        end

        // R4 / R5: request flag 2 with upper data bits set.
        lwrite(2, 8'hFE);
        both_read(2);
        check("R4 R5 left holds flag 2", lq, ZERO);
        check("R4 right not holder", rq, ONES);

        // R2: unselected read of a held flag reads ones; unselected write does nothing.
        cyc(1, 0, 2, ONES, 1, 1, 3, ZERO);
        check("R2 unselected read", lq, ONES);
        both_read(3);
        check("R2 unselected write ignored", rq, ONES);

        // R3: flag 6 taken, neighbours untouched.
        lwrite(6, ZERO);
        both_read(6);
        check("R3 left holds flag 6", lq, ZERO);
        both_read(7);
        check("R3 flag 7 untouched", lq, ONES);
        both_read(5);
        check("R3 flag 5 untouched", lq, ONES);

        // R7: right queues on flag 2; R6: right's release is ignored.
        rwrite(2, ZERO);
        both_read(2);
        check("R7 queued right not holder", rq, ONES);
        rwrite(2, 8'h01);
        both_read(2);
        check("R6 non-holder release ignored", lq, ZERO);
        lwrite(2, 8'hFF);
        both_read(2);
        check("R7 handover to right", rq, ZERO);
        check("R7 left lost flag", lq, ONES);

        // R8: tie on free flag 1 -> left wins, right queued.
        cyc(0, 1, 1, ZERO, 0, 1, 1, ZERO);
        both_read(1);
        check("R8 left wins tie", lq, ZERO);
        check("R8 right queued", rq, ONES);
        lwrite(1, 8'h01);
        both_read(1);
        check("R8 queued right gets flag", rq, ZERO);

        // R11: right frees flag 1 while left requests it in the same cycle.
        cyc(0, 1, 1, 8'hFE, 0, 1, 1, 8'h01);
        both_read(1);
        check("R11 left takes released flag", lq, ZERO);
        check("R11 right released", rq, ONES);

        // R6: release of a free flag is ignored; a later request still gets it.
        rwrite(4, 8'h01);
        lwrite(4, ZERO);
        both_read(4);
        check("R6 free-flag release ignored", lq, ZERO);

        // R5: a release with upper bits clear still frees the flag.
        lwrite(4, 8'h01);
        rwrite(4, 8'hFE);
        both_read(4);
        check("R5 bit0 only on release", rq, ZERO);

        // Random mix on a narrow address range to force contention (R7, R8, R10).
        for (int n = 0; n < 4000; n++) begin
            bit ls = ($urandom_range(0, 9) < 2);
            bit rs = ($urandom_range(0, 9) < 2);
            cyc(ls, $urandom_range(0, 1), $urandom_range(0, 3), DW'($urandom),
                rs, $urandom_range(0, 1), $urandom_range(0, 3), DW'($urandom));
        end

        // R1: reset mid-run frees everything again.
        @(negedge clk); rst_n = 0;
        @(posedge clk); model_reset();
        @(negedge clk); rst_n = 1;
        for (int a = 0; a < NF; a++) begin
            both_read(a);
            check("R1 left free after reset", lq, ONES);
            check("R1 right free after reset", rq, ONES);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule